// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B, of parameterised width. Each transfer direction owns a storage register with a capture clock of its own: the A-to-B register samples the A bus pins, and the B-to-A register samples the B bus pins. A per-direction select decides whether the bus being driven receives the live value from the opposite bus or the value held in that direction's register. An active-low output enable and a direction input choose which bus is driven, if either is.

Pads are modelled as separate input, output and per-bit output-enable vectors for each bus, so no internal tri-state exists. The path from input bus or register to the output vectors is purely combinational. The drive enables depend only on the output enable and the direction input. The registers sample on every rising edge of their clocks, whatever the enables are, so data can be stored while the buses are isolated or while a bus is being driven. Each capture domain releases the asynchronous active-low reset through its own synchroniser.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst_n` is low, both storage registers read as zero, so any output that selects stored data shows all zeros.
- R2: On a rising edge of `clk_ab`, the A-to-B register loads the value on `a_in`.
- R3: On a rising edge of `clk_ba`, the B-to-A register loads the value on `b_in`.
- R4: Captures in R2 and R3 happen for every combination of `oe_n` and `dir`, including isolation and the case where the sampled bus is the one being driven.
- R5: With `oe_n` high, `a_oe` and `b_oe` are both all zeros.
- R6: With `oe_n` low and `dir` low, `a_oe` is all ones and `b_oe` is all zeros.
- R7: With `oe_n` low and `dir` high, `b_oe` is all ones and `a_oe` is all zeros.
- R8: `a_out` equals `b_in` when `sel_ba` is 0 and the B-to-A register when `sel_ba` is 1.
- R9: `b_out` equals `a_in` when `sel_ab` is 0 and the A-to-B register when `sel_ab` is 1.
- R10: When `clk_ab` and `clk_ba` rise together, both registers load on that edge.
- R11: A register keeps its value while its clock does not rise, however its bus input changes.
- R12: After `rst_n` rises, the first two rising edges of each capture clock are ignored by that clock's register (default synchroniser depth 2). The third edge loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released per capture domain |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| oe_n | input | 1 | Active-low output enable; high isolates both buses |
| dir | input | 1 | Direction: 0 drives A, 1 drives B |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored A-to-B value |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored B-to-A value |
| a_in | input | WIDTH | Value seen on the A bus pins |
| a_out | output | WIDTH | Value offered to the A bus pads |
| a_oe | output | WIDTH | Per-bit drive enable of the A bus pads |
| b_in | input | WIDTH | Value seen on the B bus pins |
| b_out | output | WIDTH | Value offered to the B bus pads |
| b_oe | output | WIDTH | Per-bit drive enable of the B bus pads |

## Verification
Every output is combinational, so a change on the enables, selects or live bus is due in the same bench cycle. A capture pulse changes the stored value right after that pulse's rising edge, also within the cycle. The driver sets the inputs and fires any capture pulses within the first 6 ns after the bench clock rises, and pushes the expected outputs into a queue. The monitor pops and compares them at the following falling edge, 10 ns after the rising edge, when all of these results have settled. The reset-release window of R12 is tracked in the bench model as a count of edges still to be ignored.

// File: rtl/regbus_xcvr_pkg.sv
`timescale 1ns/1ps
package regbus_xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_t;

  function automatic drive_t decode_drive(input logic oe_n, input logic dir);
    if (oe_n)     return DRV_NONE;
    else if (dir) return DRV_B;
    else          return DRV_A;
  endfunction
endpackage

// File: rtl/xcvr_rst_sync.sv
`timescale 1ns/1ps
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q
);
  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_nxt;

  always_comb begin
    st_nxt = {st_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) st_q <= '0;
    else         st_q <= st_nxt;
  end

  assign rst_q = st_q[STAGES-1];

  // R12: once released, the local reset stays released until the async reset
  p_release_sticky_r12: assert property (@(posedge clk) disable iff (!arst_n)
    rst_q |=> rst_q);
endmodule

// File: rtl/xcvr_capture_reg.sv
`timescale 1ns/1ps
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R2 / R3: an edge outside the reset window loads the sampled bus value
  p_capture_r2: assert property (@(posedge clk) disable iff (!arst_n)
    rst_n |=> (q == $past(d)));

  // R1 / R12: an edge inside the reset window leaves the register cleared
  p_clear_r1: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_n |=> (q == '0));
endmodule

// File: rtl/xcvr_sel_mux.sv
`timescale 1ns/1ps
module xcvr_sel_mux #(
  parameter int WIDTH = 8
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);
  always_comb begin
    y = sel ? stored : live;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
`timescale 1ns/1ps
module xcvr_drive_ctl
  import regbus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             oe_n,
  input  logic             dir,
  output logic [WIDTH-1:0] a_oe,
  output logic [WIDTH-1:0] b_oe
);
  drive_t drv;

  always_comb begin
    drv  = decode_drive(oe_n, dir);
    a_oe = {WIDTH{drv == DRV_A}};
    b_oe = {WIDTH{drv == DRV_B}};
  end

  always_comb begin
    // R6 / R7: never both buses driven
    p_one_bus_r6: assert (!((|a_oe) && (|b_oe)));
    // R5: isolation leaves every pad undriven
    p_isolate_r5: assert (!oe_n || ((a_oe == '0) && (b_oe == '0)));
  end
endmodule

// File: rtl/regbus_xcvr.sv
`timescale 1ns/1ps
module regbus_xcvr #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe
);
  logic             rst_ab_n;
  logic             rst_ba_n;
  logic [WIDTH-1:0] reg_ab;
  logic [WIDTH-1:0] reg_ba;

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_ab (
    .clk(clk_ab), .arst_n(rst_n), .rst_q(rst_ab_n));
  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync_ba (
    .clk(clk_ba), .arst_n(rst_n), .rst_q(rst_ba_n));

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_ab (
    .clk(clk_ab), .arst_n(rst_n), .rst_n(rst_ab_n), .d(a_in), .q(reg_ab));
  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_ba (
    .clk(clk_ba), .arst_n(rst_n), .rst_n(rst_ba_n), .d(b_in), .q(reg_ba));

  xcvr_sel_mux #(.WIDTH(WIDTH)) u_mux_to_b (
    .sel(sel_ab), .live(a_in), .stored(reg_ab), .y(b_out));
  xcvr_sel_mux #(.WIDTH(WIDTH)) u_mux_to_a (
    .sel(sel_ba), .live(b_in), .stored(reg_ba), .y(a_out));

  xcvr_drive_ctl #(.WIDTH(WIDTH)) u_drive (
    .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe));
endmodule

// File: tb/regbus_xcvr_test.sv
`timescale 1ns/1ps
module regbus_xcvr_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n, clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  regbus_xcvr #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  always #10 clk = ~clk;

  typedef struct {
    logic [W-1:0] a_out;
    logic [W-1:0] a_oe;
    logic [W-1:0] b_out;
    logic [W-1:0] b_oe;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  int           vectors = 0;
  int           miscompares = 0;
  bit           done = 0;
  logic [W-1:0] m_ab, m_ba;
  int           ign_ab, ign_ba;

  task automatic step(input logic i_oe_n, input logic i_dir, input logic i_sab,
                      input logic i_sba, input logic [W-1:0] av,
                      input logic [W-1:0] bv, input logic cab, input logic cba,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    oe_n = i_oe_n; dir = i_dir; sel_ab = i_sab; sel_ba = i_sba;
    a_in = av; b_in = bv;
    #2;
    clk_ab = cab; clk_ba = cba;
    #2;
    clk_ab = 1'b0; clk_ba = 1'b0;
    if (cab && rst_n) begin
      if (ign_ab > 0) ign_ab--; else m_ab = av;
    end
    if (cba && rst_n) begin
      if (ign_ba > 0) ign_ba--; else m_ba = bv;
    end
    e.a_out = i_sba ? m_ba : bv;
    e.b_out = i_sab ? m_ab : av;
    e.a_oe  = (!i_oe_n && !i_dir) ? '1 : '0;
    e.b_oe  = (!i_oe_n &&  i_dir) ? '1 : '0;
    e.tag   = tag;
    sb.push_back(e);
  endtask

  task automatic go_reset();
    @(posedge clk);
    #1 rst_n = 1'b0;
    m_ab = '0; m_ba = '0; ign_ab = 2; ign_ba = 2;
  endtask

  task automatic release_reset();
    @(posedge clk);
    #1 rst_n = 1'b1;
    ign_ab = 2; ign_ba = 2;
  endtask

  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      vectors++;
      if (a_out !== e.a_out || a_oe !== e.a_oe ||
          b_out !== e.b_out || b_oe !== e.b_oe) begin
        miscompares++;
        $display("FAIL %s: a_out=%h a_oe=%h b_out=%h b_oe=%h expected a_out=%h a_oe=%h b_out=%h b_oe=%h",
                 e.tag, a_out, a_oe, b_out, b_oe, e.a_out, e.a_oe, e.b_out, e.b_oe);
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0;
    oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
    a_in = '0; b_in = '0;
    m_ab = '0; m_ba = '0; ign_ab = 2; ign_ba = 2;

    // R1: registers read zero in reset, capture pulses have no effect
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hA5, 8'h5A, 1'b1, 1'b1, "R1 reset A side");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5, 8'h5A, 1'b1, 1'b1, "R1 reset B side");
    release_reset();

    // R12: two edges ignored after release, shown in isolation (R5)
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h11, 8'h22, 1'b1, 1'b1, "R12 first edge R5");
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h12, 8'h23, 1'b1, 1'b1, "R12 second edge R5");
    // R10 / R4: third edge loads both together while isolated
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h33, 8'h44, 1'b1, 1'b1, "R10 R4 joint load");

    // R2 with R7
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h5C, 8'h00, 1'b1, 1'b0, "R2 R7 store A");
    // R11: no edge, input changes, value held
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h0F, 1'b0, 1'b0, "R11 hold AB");
    // R9 live
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h96, 8'h00, 1'b0, 1'b0, "R9 live A to B");
    // R3 with R6
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hC3, 1'b0, 1'b1, "R3 R6 store B");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 8'h77, 1'b0, 1'b0, "R11 hold BA");
    // R8 live
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C, 1'b0, 1'b0, "R8 live B to A");
    // R4: capture A while A is driven, then show it on B
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h7E, 8'h81, 1'b1, 1'b0, "R4 capture driven A");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, "R4 show stored A");
    // R4: capture B while B is driven, then show it on A
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hE4, 1'b0, 1'b1, "R4 capture driven B");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, "R4 show stored B");
    // R10 with outputs enabled
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h69, 8'h96, 1'b1, 1'b1, "R10 joint load driven");

    for (int i = 0; i < 16; i++) begin
      logic [W-1:0] av;
      av = W'(i * 37 + 5);
      step(i[0], i[1], i[2], i[3], av, ~av, i[1] ^ i[2], i[0] | i[3], "R8 R9 sweep");
    end

    // R1: reset in the middle of a run clears both registers
    go_reset();
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hF0, 8'h0F, 1'b0, 1'b0, "R1 mid-run reset A");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hF0, 8'h0F, 1'b1, 1'b1, "R1 mid-run reset B");
    release_reset();
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hAB, 8'hCD, 1'b1, 1'b0, "R12 edge one AB");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hAC, 8'hCE, 1'b1, 1'b0, "R12 edge two AB");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hAD, 8'hCF, 1'b1, 1'b0, "R12 edge three AB");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0, "R12 BA still clear");

    repeat (2) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule